// File: doc/BRIEF.md
# EDO DRAM Page-Mode Access Controller

This block sits between a simple host port and one 16-bit extended-data-out DRAM that has a separate column strobe per byte. A host request carries a word address, a read/write flag, write data and a two-bit byte mask. The controller splits the address into a row part and a column part and drives them over a shared address bus. It then produces the row strobe, the two column strobes, write enable and output enable. Read data is captured after the column strobes have risen, while the memory still holds it on the bus, and is returned together with a one-cycle valid pulse.

Once a row is open, it stays open. Requests that hit the open row run as short page-mode column cycles. A request to another row, a refresh request, or the row-active time limit closes the row and precharges it. Refresh uses the column-before-row method. It is taken only while the row is closed, and it is acknowledged with a pulse. All DRAM timing is given in nanoseconds and converted to clock cycles from the clock-period parameter.

Top module: `edo_page_ctrl`

## Requirements
- R1: After reset the row strobe, both column strobes, write enable and output enable are high (inactive), the data-bus drive enable is low and rd_valid is low.
- R2: The upper ROW_BITS bits of the host address go on the address bus when the row strobe falls, and the lower ADDR_W-ROW_BITS bits go on it when the column strobes fall. ROW_BITS=12 gives a 12/8 split and ROW_BITS=10 gives a 10/10 split.
- R3: In a write, mask bit 0 pulls the lower column strobe low, which writes data bits 7:0. Mask bit 1 pulls the upper strobe low, which writes bits 15:8. A lane whose mask bit is 0 keeps its stored value.
- R4: A read pulls both column strobes low and samples the data bus after they have risen again, no earlier than the column-strobe, column-address and row-strobe access times. rd_data is returned with a single-cycle rd_valid pulse.
- R5: A request to the open row is served without the row strobe rising.
- R6: A request to another row raises the row strobe, holds it high for at least the row precharge time, and then reopens the row with the new address.
- R7: The row strobe never stays low for MAX_RAS_NS/CLK_NS cycles or more. The row is closed before this limit even when more same-row requests are waiting.
- R8: A refresh request is served only with the row closed. Both column strobes fall before the row strobe, and ref_ack pulses while the row strobe is still high. req_ready stays low while a refresh is pending or running.
- R9: The data-bus drive enable is never high while output enable is low. Output enable only falls after the drive enable has been low for at least one cycle.
- R10: Every write is an early write. Write enable is low at least one cycle before the column strobes fall, and output enable stays high during it.
- R11: The row strobe stays low for at least the row-active time. There are at least two cycles from the row strobe falling to the column strobes falling, and both column strobes are high for at least one cycle between column accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller takes the request at this edge |
| req_addr | input | ADDR_W | Word address |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte enables, bit 0 = bits 7:0 |
| rd_data | output | 16 | Read data |
| rd_valid | output | 1 | One-cycle pulse with rd_data |
| ref_req | input | 1 | Refresh request from arbiter |
| ref_ack | output | 1 | Pulse when refresh is started |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_l_n | output | 1 | Lower byte column strobe, active low |
| dram_cas_u_n | output | 1 | Upper byte column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | max(ROW_BITS, ADDR_W-ROW_BITS) | Multiplexed address bus |
| dram_dq_out | output | 16 | Data driven toward memory |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 16 | Data returned from memory |

## Verification
The assertions assume that ref_req stays high until ref_ack, that host request fields are stable while req_valid waits for req_ready, and that MAX_RAS_NS leaves room for a few page cycles after the row-active minimum. The bench keeps to these assumptions. Its host task holds every field steady from the time it raises req_valid until the accepting edge. The refresh request is held until the acknowledge is seen. The row limit is set to 100 cycles, which is short enough that long same-row bursts run into it.

// File: rtl/edo_pkg.sv
package edo_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_ROW, ST_RCD, ST_COL, ST_CAS,
        ST_CPH, ST_OPEN, ST_PRE, ST_RF_CAS, ST_RF_RAS
    } edo_st_e;

    function automatic int cdiv(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/edo_addr_split.sv
module edo_addr_split #(
    parameter int ADDR_W   = 20,
    parameter int ROW_BITS = 10,
    parameter int COL_BITS = ADDR_W - ROW_BITS,
    parameter int BUS_W    = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [ROW_BITS-1:0] row_f,
    output logic [BUS_W-1:0]    row_bus,
    output logic [BUS_W-1:0]    col_bus
);
    logic [COL_BITS-1:0] col_f;

    assign row_f = addr[ADDR_W-1 -: ROW_BITS];
    assign col_f = addr[COL_BITS-1:0];

    generate
        if (ROW_BITS == BUS_W) begin : g_row_full
            assign row_bus = row_f;
        end else begin : g_row_pad
            assign row_bus = {{(BUS_W-ROW_BITS){1'b0}}, row_f};
        end
        if (COL_BITS == BUS_W) begin : g_col_full
            assign col_bus = col_f;
        end else begin : g_col_pad
            assign col_bus = {{(BUS_W-COL_BITS){1'b0}}, col_f};
        end
    endgenerate
endmodule

// File: rtl/edo_ras_timer.sv
module edo_ras_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ras_n,
    output logic [CW-1:0] low_cnt,
    output logic [CW-1:0] hi_cnt
);
    localparam logic [CW-1:0] SAT = '1;

    logic [CW-1:0] low_d, low_q, hi_d, hi_q;

    always_comb begin
        low_d = '0;
        hi_d  = '0;
        if (ras_n) begin
            hi_d = (hi_q == SAT) ? hi_q : hi_q + 1'b1;
        end else begin
            low_d = (low_q == SAT) ? low_q : low_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_q <= '0;
            hi_q  <= SAT;
        end else begin
            low_q <= low_d;
            hi_q  <= hi_d;
        end
    end

    assign low_cnt = low_q;
    assign hi_cnt  = hi_q;
endmodule

// File: rtl/edo_page_ctrl.sv
module edo_page_ctrl
    import edo_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int ROW_BITS   = 10,
    parameter int CLK_NS     = 10,
    parameter int MAX_RAS_NS = 100000,
    parameter int T_RC_NS    = 110,
    parameter int T_RAS_NS   = 60,
    parameter int T_RP_NS    = 40,
    parameter int T_PC_NS    = 25,
    parameter int T_CAS_NS   = 10,
    parameter int T_CP_NS    = 10,
    parameter int T_RCD_NS   = 15,
    parameter int T_CAC_NS   = 15,
    parameter int T_AA_NS    = 30,
    parameter int T_RAC_NS   = 60
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic                req_wr,
    input  logic [15:0]         req_wdata,
    input  logic [1:0]          req_mask,
    output logic [15:0]         rd_data,
    output logic                rd_valid,
    input  logic                ref_req,
    output logic                ref_ack,
    output logic                dram_ras_n,
    output logic                dram_cas_l_n,
    output logic                dram_cas_u_n,
    output logic                dram_we_n,
    output logic                dram_oe_n,
    output logic [((ROW_BITS > ADDR_W-ROW_BITS) ? ROW_BITS : ADDR_W-ROW_BITS)-1:0] dram_addr,
    output logic [15:0]         dram_dq_out,
    output logic                dram_dq_oe,
    input  logic [15:0]         dram_dq_in
);
    localparam int COL_BITS = ADDR_W - ROW_BITS;
    localparam int BUS_W    = imax(ROW_BITS, COL_BITS);
    localparam int C_RCD    = imax(2, cdiv(T_RCD_NS, CLK_NS));
    localparam int C_CAS    = imax(1, cdiv(T_CAS_NS, CLK_NS));
    localparam int C_CPH    = imax(imax(1, cdiv(T_CP_NS, CLK_NS)),
                              imax(cdiv(T_CAC_NS, CLK_NS) - C_CAS,
                              imax(cdiv(T_AA_NS, CLK_NS) - 1 - C_CAS,
                                   cdiv(T_PC_NS, CLK_NS) - 1 - C_CAS)));
    localparam int C_RAS    = imax(1, cdiv(T_RAS_NS, CLK_NS));
    localparam int C_RP     = imax(cdiv(T_RP_NS, CLK_NS), cdiv(T_RC_NS, CLK_NS) - C_RAS - 1);
    localparam int C_RAC    = cdiv(T_RAC_NS, CLK_NS);
    localparam int C_PAGE   = 1 + C_CAS + C_CPH;
    localparam int C_MAX    = MAX_RAS_NS / CLK_NS;
    localparam int C_LIM    = C_MAX - C_PAGE - 2;
    localparam int CNT_W    = $clog2(imax(imax(C_RCD, C_CPH), imax(C_RAS, C_RP)) + 1) + 1;
    localparam int RC_W     = $clog2(C_MAX + 2) + 1;

    typedef struct packed {
        edo_st_e             st;
        logic [CNT_W-1:0]    cnt;
        logic                ras_n;
        logic [1:0]          cas_n;   // bit 0 lower lane, bit 1 upper lane
        logic                we_n;
        logic                oe_n;
        logic [BUS_W-1:0]    addr;
        logic [15:0]         dq;
        logic                dq_oe;
        logic [ROW_BITS-1:0] row;
        logic [BUS_W-1:0]    col;
        logic                is_wr;
        logic [1:0]          mask;
        logic [15:0]         rdat;
        logic                rvld;
        logic                rack;
    } regs_t;

    regs_t r_d, r_q;

    logic [ROW_BITS-1:0] row_f;
    logic [BUS_W-1:0]    row_bus, col_bus;
    logic [RC_W-1:0]     low_cnt, hi_cnt;
    logic                hit, can_close, must_close, rac_ok, accept;

    edo_addr_split #(.ADDR_W(ADDR_W), .ROW_BITS(ROW_BITS)) u_split (
        .addr(req_addr), .row_f(row_f), .row_bus(row_bus), .col_bus(col_bus)
    );

    edo_ras_timer #(.CW(RC_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .ras_n(r_q.ras_n),
        .low_cnt(low_cnt), .hi_cnt(hi_cnt)
    );

    assign hit        = (row_f == r_q.row);
    assign can_close  = (low_cnt >= RC_W'(C_RAS - 1));
    assign must_close = (low_cnt >= RC_W'(C_LIM));
    assign rac_ok     = (low_cnt >= RC_W'(C_RAC - 1));

    always_comb begin
        case (r_q.st)
            ST_IDLE: req_ready = !ref_req;
            ST_OPEN: req_ready = hit && !ref_req && !must_close;
            default: req_ready = 1'b0;
        endcase
    end
    assign accept = req_valid && req_ready;

    always_comb begin
        r_d      = r_q;
        r_d.rvld = 1'b0;
        r_d.rack = 1'b0;
        if (accept) begin
            r_d.row   = row_f;
            r_d.col   = col_bus;
            r_d.is_wr = req_wr;
            r_d.mask  = req_mask;
            r_d.dq    = req_wdata;
            r_d.dq_oe = req_wr;
            r_d.we_n  = !req_wr;
        end
        case (r_q.st)
            ST_IDLE: begin
                if (ref_req) begin
                    r_d.cas_n = 2'b00;
                    r_d.rack  = 1'b1;
                    r_d.st    = ST_RF_CAS;
                end else if (req_valid) begin
                    r_d.addr = row_bus;
                    r_d.st   = ST_ROW;
                end
            end
            ST_ROW: begin
                r_d.ras_n = 1'b0;
                r_d.cnt   = CNT_W'(C_RCD - 1);
                r_d.st    = ST_RCD;
            end
            ST_RCD: begin
                r_d.addr = r_q.col;
                if (r_q.cnt == '0) begin
                    r_d.cas_n = r_q.is_wr ? ~r_q.mask : 2'b00;
                    r_d.oe_n  = r_q.is_wr;
                    r_d.cnt   = CNT_W'(C_CAS - 1);
                    r_d.st    = ST_CAS;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_COL: begin
                r_d.cas_n = r_q.is_wr ? ~r_q.mask : 2'b00;
                r_d.oe_n  = r_q.is_wr;
                r_d.cnt   = CNT_W'(C_CAS - 1);
                r_d.st    = ST_CAS;
            end
            ST_CAS: begin
                if (r_q.cnt == '0) begin
                    r_d.cas_n = 2'b11;
                    r_d.we_n  = 1'b1;
                    r_d.dq_oe = 1'b0;
                    r_d.cnt   = CNT_W'(C_CPH - 1);
                    r_d.st    = ST_CPH;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_CPH: begin
                if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end else if (r_q.is_wr) begin
                    r_d.st = ST_OPEN;
                end else if (rac_ok) begin
                    r_d.rdat = dram_dq_in;
                    r_d.rvld = 1'b1;
                    r_d.oe_n = 1'b1;
                    r_d.st   = ST_OPEN;
                end
            end
            ST_OPEN: begin
                if (accept) begin
                    r_d.addr = col_bus;
                    r_d.st   = ST_COL;
                end else if (can_close && (must_close || ref_req || (req_valid && !hit))) begin
                    r_d.ras_n = 1'b1;
                    r_d.cnt   = CNT_W'(C_RP - 1);
                    r_d.st    = ST_PRE;
                end
            end
            ST_PRE: begin
                if (r_q.cnt == '0) r_d.st = ST_IDLE;
                else               r_d.cnt = r_q.cnt - 1'b1;
            end
            ST_RF_CAS: begin
                r_d.ras_n = 1'b0;
                r_d.cnt   = CNT_W'(C_RAS - 1);
                r_d.st    = ST_RF_RAS;
            end
            ST_RF_RAS: begin
                if (r_q.cnt == '0) begin
                    r_d.ras_n = 1'b1;
                    r_d.cas_n = 2'b11;
                    r_d.cnt   = CNT_W'(C_RP - 1);
                    r_d.st    = ST_PRE;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
            r_q.ras_n <= 1'b1;
            r_q.cas_n <= 2'b11;
            r_q.we_n  <= 1'b1;
            r_q.oe_n  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_data      = r_q.rdat;
    assign rd_valid     = r_q.rvld;
    assign ref_ack      = r_q.rack;
    assign dram_ras_n   = r_q.ras_n;
    assign dram_cas_l_n = r_q.cas_n[0];
    assign dram_cas_u_n = r_q.cas_n[1];
    assign dram_we_n    = r_q.we_n;
    assign dram_oe_n    = r_q.oe_n;
    assign dram_addr    = r_q.addr;
    assign dram_dq_out  = r_q.dq;
    assign dram_dq_oe   = r_q.dq_oe;

    AST_BUS_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        dram_dq_oe |-> dram_oe_n); // R9
    AST_OE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_oe_n) |-> !$past(dram_dq_oe)); // R9
    AST_EARLY_WE: assert property (@(posedge clk) disable iff (!rst_n)
        (($fell(dram_cas_l_n) || $fell(dram_cas_u_n)) && !dram_we_n) |-> $past(!dram_we_n)); // R10
    AST_RAS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_ras_n |-> (low_cnt < RC_W'(C_MAX))); // R7
    AST_RP_MET: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> (hi_cnt >= RC_W'(C_RP))); // R6
    AST_REF_ROW_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        ref_ack |-> (dram_ras_n && !dram_cas_l_n && !dram_cas_u_n)); // R8
    AST_RDV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid); // R4
endmodule

// File: tb/edo_page_ctrl_bench.sv
module edo_page_ctrl_bench;
    localparam int RB = 12;
    localparam int CB = 20 - RB;
    localparam int MAXC = 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_wr = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic ref_req = 1'b0;
    logic req_ready, rd_valid, ref_ack;
    logic [15:0] rd_data, dq_out, dq_in;
    logic ras_n, casl_n, casu_n, we_n, oe_n, dq_oe;
    logic [RB-1:0] dram_addr;

    always #5 clk = ~clk;

    edo_page_ctrl #(.ADDR_W(20), .ROW_BITS(RB), .MAX_RAS_NS(MAXC*10)) u_edo_page_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_wr(req_wr), .req_wdata(req_wdata), .req_mask(req_mask),
        .rd_data(rd_data), .rd_valid(rd_valid), .ref_req(ref_req), .ref_ack(ref_ack),
        .dram_ras_n(ras_n), .dram_cas_l_n(casl_n), .dram_cas_u_n(casu_n),
        .dram_we_n(we_n), .dram_oe_n(oe_n), .dram_addr(dram_addr),
        .dram_dq_out(dq_out), .dram_dq_oe(dq_oe), .dram_dq_in(dq_in)
    );

    // memory model
    bit [15:0] mem [int];
    bit [15:0] exp_m [int];
    logic [RB-1:0] row_l = '0;
    logic [CB-1:0] col_l = '0;
    logic [15:0] rd_word = '0;
    wire any_lo = ~(casl_n & casu_n);

    always @(negedge ras_n) row_l = dram_addr;
    always @(posedge any_lo) begin
        if (!ras_n) begin
            int k;
            bit [15:0] w;
            col_l = dram_addr[CB-1:0];
            k = int'({row_l, col_l});
            w = mem.exists(k) ? mem[k] : 16'h0;
            if (!we_n) begin
                if (!casl_n) w[7:0]  = dq_out[7:0];
                if (!casu_n) w[15:8] = dq_out[15:8];
                mem[k] = w;
            end
            rd_word = w;
        end
    end
    assign dq_in = (!oe_n && we_n) ? rd_word : 16'h0;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // monitor
    logic [19:0] acc_addr = '0;
    int ras_falls = 0, cbr_cnt = 0, max_lo = 0;
    int lo_len = 0, hi_len = 1000, cas_hi_len = 1000;
    int v_rp = 0, v_ras = 0, v_rcd = 0, v_cp = 0, v_early = 0, v_bus = 0, v_split = 0, v_refrdy = 0;
    logic p_ras = 1, p_any = 0, p_we = 1, p_oe = 1, p_dqoe = 0;

    always @(negedge clk) if (rst_n) begin
        if (p_ras && !ras_n) begin
            ras_falls++;
            if (hi_len < 4) v_rp++;
            if (!any_lo) begin
                if (dram_addr != acc_addr[19 -: RB]) v_split++;
            end else begin
                cbr_cnt++;
                if (req_ready) v_refrdy++;
            end
        end
        if (!p_ras && ras_n && lo_len < 6) v_ras++;
        if (!p_any && any_lo && !ras_n) begin
            if (lo_len < 2) v_rcd++;
            if (cas_hi_len < 1) v_cp++;
            if (dram_addr[CB-1:0] != acc_addr[CB-1:0]) v_split++;
            if (!we_n && p_we) v_early++;
        end
        if (!we_n && !oe_n) v_early++;
        if (dq_oe && !oe_n) v_bus++;
        if (p_oe && !oe_n && p_dqoe) v_bus++;
        if (ref_req && req_ready) v_refrdy++;
        if (!ras_n) begin lo_len++; hi_len = 0; end else begin hi_len++; lo_len = 0; end
        if (lo_len > max_lo) max_lo = lo_len;
        if (any_lo) cas_hi_len = 0; else cas_hi_len++;
        p_ras = ras_n; p_any = any_lo; p_we = we_n; p_oe = oe_n; p_dqoe = dq_oe;
    end

    task automatic host_op(input logic [19:0] a, input logic wr, input logic [15:0] d,
                           input logic [1:0] m, output logic [15:0] q);
        @(negedge clk);
        req_addr = a; req_wr = wr; req_wdata = d; req_mask = m; req_valid = 1'b1;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        acc_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        q = '0;
        if (!wr) begin
            while (!rd_valid) @(negedge clk);
            q = rd_data;
        end
    endtask

    task automatic do_write(input logic [19:0] a, input logic [15:0] d, input logic [1:0] m);
        logic [15:0] q;
        bit [15:0] e;
        int k;
        k = int'(a);
        e = exp_m.exists(k) ? exp_m[k] : 16'h0;
        if (m[0]) e[7:0]  = d[7:0];
        if (m[1]) e[15:8] = d[15:8];
        exp_m[k] = e;
        host_op(a, 1'b1, d, m, q);
    endtask

    task automatic do_read(input logic [19:0] a, input string req);
        logic [15:0] q;
        bit [15:0] e;
        int k;
        k = int'(a);
        e = exp_m.exists(k) ? exp_m[k] : 16'h0;
        host_op(a, 1'b0, 16'h0, 2'b11, q);
        chk(q === e, req, q, e);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [11:0] rows [4];
        logic [7:0]  cols [4];
        int f0, c0;
        rows = '{12'h000, 12'h001, 12'hFFF, 12'h5A5};
        cols = '{8'h00, 8'h01, 8'hFF, 8'h3C};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk({ras_n, casl_n, casu_n, we_n, oe_n} == 5'b11111, "R1 strobes idle", {ras_n, casl_n, casu_n, we_n, oe_n}, 5'b11111);
        chk(!dq_oe && !rd_valid, "R1 drive and valid low", {dq_oe, rd_valid}, 0);

        // R3/R4 sweep: full writes, lane writes, null-mask writes, then reads
        foreach (rows[i]) foreach (cols[j]) begin
            logic [19:0] a;
            a = {rows[i], cols[j]};
            do_write(a, a[15:0] ^ 16'hC3A5, 2'b11);
            do_write(a, {a[7:0], a[19:12]} ^ 16'h0F0F, 2'b01);
            do_write(a, a[19:4] + 16'h1234, 2'b10);
            do_write(a, 16'hDEAD, 2'b00);
        end
        foreach (rows[i]) foreach (cols[j]) do_read({rows[i], cols[j]}, "R3 R4 lane merge readback");

        // R2 row/column split seen by the memory model
        foreach (exp_m[k]) chk(mem.exists(k) && mem[k] == exp_m[k], "R2 split key", mem.exists(k) ? mem[k] : 0, exp_m[k]);

        // R5 page hits: one row-strobe fall for a same-row burst from closed row
        do_read(20'hABC00, "R6 reopen");
        f0 = ras_falls;
        do_write(20'h12305, 16'h5555, 2'b11);
        do_write(20'h12306, 16'hAAAA, 2'b01);
        do_read(20'h12305, "R5 page read");
        do_read(20'h12306, "R5 page read");
        chk(ras_falls - f0 == 1, "R5 one row open for burst", ras_falls - f0, 1);

        // R6 row miss reopens
        f0 = ras_falls;
        do_read(20'h45600, "R6 miss read");
        do_read(20'h12305, "R6 miss read back");
        chk(ras_falls - f0 == 2, "R6 miss reopens row", ras_falls - f0, 2);

        // R8 refresh while a row is open
        c0 = cbr_cnt;
        @(negedge clk);
        ref_req = 1'b1;
        while (!ref_ack) @(negedge clk);
        chk(ras_n && !casl_n && !casu_n, "R8 ack with row closed", {ras_n, casl_n, casu_n}, 3'b100);
        ref_req = 1'b0;
        repeat (20) @(negedge clk);
        chk(cbr_cnt - c0 == 1, "R8 one refresh cycle", cbr_cnt - c0, 1);
        do_read(20'h12306, "R8 data kept after refresh");

        // R7 long same-row burst is broken up by the limit
        f0 = ras_falls;
        for (int n = 0; n < 40; n++) do_read({12'h777, 8'(n)}, "R7 burst read");
        chk(ras_falls - f0 >= 2, "R7 row closed during burst", ras_falls - f0, 2);
        chk(max_lo < MAXC, "R7 max row-low cycles", max_lo, MAXC);

        repeat (10) @(negedge clk);
        chk(v_rp == 0, "R6 precharge violations", v_rp, 0);
        chk(v_ras == 0 && v_rcd == 0 && v_cp == 0, "R11 strobe timing violations", v_ras + v_rcd + v_cp, 0);
        chk(v_early == 0, "R10 early write violations", v_early, 0);
        chk(v_bus == 0, "R9 bus turnaround violations", v_bus, 0);
        chk(v_split == 0, "R2 address split violations", v_split, 0);
        chk(v_refrdy == 0, "R8 ready during refresh", v_refrdy, 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule